// File: doc/BRIEF.md
# Data Object Exchange Mailbox Controller

This block is a register-mapped mailbox through which host software hands a request data object to a device one 32-bit dword at a time, and then collects the response object the same way. Software reaches it through a simple configuration read/write port that addresses a 24-byte register window. Dwords written to the request mailbox collect in a request buffer. A GO command then checks the object's first header dword against a parameter table of supported protocols, and checks its length field against the number of dwords actually written. A request that passes both checks goes to a responder over a start/done handshake. A request that fails either check is dropped silently.

The responder reads the request through a synchronous read port and pushes response dwords into a response buffer. It then reports done, or reports discard when it cannot serve the request. A finished response raises the ready flag. Software reads the current response dword from the read mailbox and writes any value there to step to the next one. Ready clears by itself after the last dword is consumed. When ready or error becomes set, a one-cycle interrupt request pulse is produced, provided interrupts are supported and enabled.

Top module: `doe_mailbox`

## Requirements
- R1: After reset, control and status read as 0, `irq` and `rsp_start` are low, and the capability register reads `{20'b0, INTR_VEC, INTR_SUP}` (0x0000000B with the defaults INTR_VEC=5 and INTR_SUP=1).
- R2: The dword registers are decoded from `cfg_addr[4:2]`: capability 1, control 2, status 3, request mailbox 4, response mailbox 5. `cfg_addr[1:0]` must be 0. Any other address reads 0 and ignores writes. The capability register carries interrupt-supported in bit 0 and the message number in bits 11:1.
- R3: Control bit 0 is ABORT, bit 1 is interrupt enable, and bit 31 is GO. Every control write loads the enable from bit 1. Reads return the enable in bit 1 and always return 0 in bits 0 and 31.
- R4: Each write to the request mailbox appends the dword at the next position. The write is ignored while busy or ready. Once DEPTH dwords are held, further writes are dropped and the next GO discards the request.
- R5: A GO accepts the request when dword 0 equals a table entry packed as (type << 16) | vendor (defaults: index 0 = 0x00000001, index 1 = 0x00010001, index 2 = 0x00421AB3, with the lowest index winding a tie), at least 2 dwords were written, and bits 17:0 of dword 1 equal the dword count. Bits 31:18 of dword 1 are not compared. An accepted GO gives a one-cycle `rsp_start` pulse and the matching index on `rsp_proto`, and `req_rdata` returns the dword at `req_raddr` one cycle later.
- R6: A GO with an unknown protocol, a length mismatch, fewer than 2 dwords or an overflowed buffer is discarded silently. There is no `rsp_start`, busy and ready stay low, and the request buffer is emptied so that the next object starts at position 0.
- R7: Status bit 0 (busy) stays high from an accepted GO until `rsp_done` or `rsp_discard`. GO is ignored while busy or ready.
- R8: `rsp_done` while busy clears busy and sets status bit 31 (ready) when the response holds at least one dword. `rsp_discard` while busy clears busy, sets status bit 2 (error) and empties both buffers.
- R9: A read of the response mailbox returns the current response dword while ready is set, and returns 0 otherwise.
- R10: A write of any value to the response mailbox while ready advances to the next dword. The write that consumes the last dword clears ready and empties both buffers.
- R11: Writing ABORT clears busy, ready and error and empties both buffers. ABORT takes priority over GO in the same write.
- R12: When ready or error becomes set while INTR_SUP is 1 and the enable is set, `irq` pulses high for one cycle and status bit 1 is set. Writing 1 to status bit 1 clears it.
- R13: `cfg_rdata` holds the value of a read in the cycle after the cycle in which `cfg_rd` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe |
| cfg_addr | input | 5 | Byte offset in the register window |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, one cycle after the read strobe |
| rsp_start | output | 1 | One-cycle pulse for an accepted request |
| rsp_proto | output | PW | Index of the matched protocol |
| req_raddr | input | AW | Request buffer read address from the responder |
| req_rdata | output | 32 | Request dword, one cycle after the address |
| rsp_wr | input | 1 | Responder pushes one response dword |
| rsp_wdata | input | 32 | Response dword |
| rsp_done | input | 1 | Responder finished; response complete |
| rsp_discard | input | 1 | Responder rejects the request |
| irq | output | 1 | Interrupt request pulse |

## Verification
Register writes, GO, pops, done and discard all take effect at the first clock edge after the inputs are driven. So `rsp_start`, `irq` and the busy, ready and error flags are sampled at the falling edge that follows that edge. A register read and a request-buffer read each return one edge later, and the bench samples them at the next falling edge. All inputs change on falling edges. Randomized transactions mix valid, mislabelled, wrong-length and overflowing requests with random response lengths and interrupt enables, and expected values come from the bench's own copy of the protocol table.

// File: rtl/doe_mbx_pkg.sv
package doe_mbx_pkg;
  // Dword register selectors (cfg_addr[4:2]); the layout is fixed by software.
  localparam logic [2:0] SEL_CAP  = 3'd1;
  localparam logic [2:0] SEL_CTRL = 3'd2;
  localparam logic [2:0] SEL_STAT = 3'd3;
  localparam logic [2:0] SEL_WMB  = 3'd4;
  localparam logic [2:0] SEL_RMB  = 3'd5;

  // Control and status bit positions.
  localparam int CTL_ABORT = 0;
  localparam int CTL_IEN   = 1;
  localparam int CTL_GO    = 31;
  localparam int ST_BUSY   = 0;
  localparam int ST_ISTS   = 1;
  localparam int ST_ERR    = 2;
  localparam int ST_RDY    = 31;

  // Width of the object length field in header dword 1.
  localparam int LEN_W = 18;
endpackage

// File: rtl/doe_req_buf.sv
module doe_req_buf #(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1),
  parameter int LW    = 18
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [31:0]   wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [31:0]   rd_data,
  output logic [CW-1:0] count,
  output logic          overflow,
  output logic [31:0]   hdr0,
  output logic [LW-1:0] hdr_len
);
  logic [31:0] mem [DEPTH];
  logic        room;

  assign room = (count < CW'(DEPTH));

  // Storage without reset so it maps onto block RAM.
  always_ff @(posedge clk) begin
    if (wr_en && room) mem[count[AW-1:0]] <= wr_data;
    rd_data <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count    <= '0;
      overflow <= 1'b0;
      hdr0     <= '0;
      hdr_len  <= '0;
    end else if (wr_en) begin
      if (room) begin
        count <= count + CW'(1);
        if (count == CW'(0)) hdr0 <= wr_data;
        if (count == CW'(1)) hdr_len <= wr_data[LW-1:0];
      end else begin
        overflow <= 1'b1;
      end
    end
  end

  p_count_bound_r4: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  p_overflow_only_full_r4: assert property (@(posedge clk) disable iff (rst)
    overflow |-> (count == CW'(DEPTH)));
endmodule

// File: rtl/doe_rsp_buf.sv
module doe_rsp_buf #(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [31:0]   wr_data,
  input  logic          pop,
  output logic [31:0]   q,
  output logic [CW-1:0] len,
  output logic [CW-1:0] idx
);
  logic [31:0] mem [DEPTH];
  logic        room;

  assign room = (len < CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (wr_en && room) mem[len[AW-1:0]] <= wr_data;
    q <= mem[idx[AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      len <= '0;
      idx <= '0;
    end else begin
      if (wr_en && room) len <= len + CW'(1);
      if (pop) idx <= idx + CW'(1);
    end
  end

  p_idx_bound_r10: assert property (@(posedge clk) disable iff (rst)
    idx <= len);
endmodule

// File: rtl/doe_proto_match.sv
module doe_proto_match #(
  parameter int NPROT = 3,
  parameter int PW    = 2,
  parameter logic [NPROT-1:0][31:0] PROTOS = '0
) (
  input  logic [31:0]   hdr,
  output logic          hit,
  output logic [PW-1:0] idx
);
  logic [NPROT-1:0] eq;

  for (genvar g = 0; g < NPROT; g++) begin : g_cmp
    assign eq[g] = (hdr == PROTOS[g]);
  end

  // Lowest matching index wins.
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = NPROT - 1; i >= 0; i--) begin
      if (eq[i]) begin
        hit = 1'b1;
        idx = PW'(i);
      end
    end
  end
endmodule

// File: rtl/doe_mailbox.sv
module doe_mailbox
  import doe_mbx_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int NPROT    = 3,
  parameter logic [NPROT-1:0][31:0] PROTOS =
    {32'h0042_1AB3, 32'h0001_0001, 32'h0000_0001},
  parameter bit          INTR_SUP = 1'b1,
  parameter logic [10:0] INTR_VEC = 11'd5,
  parameter int AW = $clog2(DEPTH),
  parameter int PW = (NPROT > 1) ? $clog2(NPROT) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_wr,
  input  logic          cfg_rd,
  input  logic [4:0]    cfg_addr,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  output logic          rsp_start,
  output logic [PW-1:0] rsp_proto,
  input  logic [AW-1:0] req_raddr,
  output logic [31:0]   req_rdata,
  input  logic          rsp_wr,
  input  logic [31:0]   rsp_wdata,
  input  logic          rsp_done,
  input  logic          rsp_discard,
  output logic          irq
);
  localparam int CW = $clog2(DEPTH + 1);

  // Address decode
  logic       aligned;
  logic [2:0] sel;
  assign aligned = (cfg_addr[1:0] == 2'b00);
  assign sel     = aligned ? cfg_addr[4:2] : 3'd0;

  // State
  logic busy, ready, error, ists, intr_en;

  // Buffer interfaces
  logic [CW-1:0]    req_cnt, rsp_len, rsp_idx;
  logic             req_ovf;
  logic [31:0]      req_hdr0, rsp_q;
  logic [LEN_W-1:0] req_len;
  logic             hit;
  logic [PW-1:0]    hit_idx;

  // Command decode
  logic wr_ctrl, abort_w, go_w, go_take, req_ok, acc;
  logic fin_ok, fin_bad, pop_w, last_pop, req_clr, rsp_clr;
  logic busy_n, ready_n, error_n, irq_n;

  assign wr_ctrl  = cfg_wr && (sel == SEL_CTRL);
  assign abort_w  = wr_ctrl && cfg_wdata[CTL_ABORT];
  assign go_w     = wr_ctrl && !cfg_wdata[CTL_ABORT] && cfg_wdata[CTL_GO];
  assign go_take  = go_w && !busy && !ready;
  assign req_ok   = hit && !req_ovf && (req_cnt >= CW'(2)) &&
                    (req_len == LEN_W'(req_cnt));
  assign acc      = go_take && req_ok;
  assign fin_bad  = busy && rsp_discard;
  assign fin_ok   = busy && rsp_done && !rsp_discard;
  assign pop_w    = cfg_wr && (sel == SEL_RMB) && ready;
  assign last_pop = pop_w && ((rsp_idx + CW'(1)) >= rsp_len);
  assign req_clr  = abort_w || (go_take && !req_ok) || last_pop || fin_bad;
  assign rsp_clr  = abort_w || last_pop || fin_bad;

  doe_proto_match #(.NPROT(NPROT), .PW(PW), .PROTOS(PROTOS)) u_match (
    .hdr (req_hdr0),
    .hit (hit),
    .idx (hit_idx)
  );

  doe_req_buf #(.DEPTH(DEPTH), .AW(AW), .CW(CW), .LW(LEN_W)) u_req (
    .clk      (clk),
    .rst      (rst),
    .clr      (req_clr),
    .wr_en    (cfg_wr && (sel == SEL_WMB) && !busy && !ready),
    .wr_data  (cfg_wdata),
    .rd_addr  (req_raddr),
    .rd_data  (req_rdata),
    .count    (req_cnt),
    .overflow (req_ovf),
    .hdr0     (req_hdr0),
    .hdr_len  (req_len)
  );

  doe_rsp_buf #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_rsp (
    .clk     (clk),
    .rst     (rst),
    .clr     (rsp_clr),
    .wr_en   (rsp_wr && busy),
    .wr_data (rsp_wdata),
    .pop     (pop_w),
    .q       (rsp_q),
    .len     (rsp_len),
    .idx     (rsp_idx)
  );

  // Next-state of the handshake flags
  always_comb begin
    busy_n  = busy;
    ready_n = ready;
    error_n = error;
    if (abort_w) begin
      busy_n  = 1'b0;
      ready_n = 1'b0;
      error_n = 1'b0;
    end else begin
      if (acc) busy_n = 1'b1;
      if (fin_ok) begin
        busy_n  = 1'b0;
        ready_n = (rsp_len != '0) || rsp_wr;
      end
      if (fin_bad) begin
        busy_n  = 1'b0;
        error_n = 1'b1;
      end
      if (last_pop) ready_n = 1'b0;
    end
    irq_n = INTR_SUP && intr_en &&
            ((ready_n && !ready) || (error_n && !error));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      ready     <= 1'b0;
      error     <= 1'b0;
      ists      <= 1'b0;
      intr_en   <= 1'b0;
      irq       <= 1'b0;
      rsp_start <= 1'b0;
      rsp_proto <= '0;
    end else begin
      busy      <= busy_n;
      ready     <= ready_n;
      error     <= error_n;
      irq       <= irq_n;
      rsp_start <= acc;
      if (acc) rsp_proto <= hit_idx;
      if (wr_ctrl) intr_en <= cfg_wdata[CTL_IEN];
      if (irq_n) ists <= 1'b1;
      else if (cfg_wr && (sel == SEL_STAT) && cfg_wdata[ST_ISTS]) ists <= 1'b0;
    end
  end

  // Read path: one register stage; the mailbox word comes from the RAM output.
  logic [31:0] rd_reg;
  logic        rd_mb;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_reg <= '0;
      rd_mb  <= 1'b0;
    end else begin
      rd_mb <= cfg_rd && (sel == SEL_RMB) && ready;
      if (cfg_rd) begin
        case (sel)
          SEL_CAP:  rd_reg <= {20'b0, INTR_VEC, INTR_SUP};
          SEL_CTRL: rd_reg <= {30'b0, intr_en, 1'b0};
          SEL_STAT: rd_reg <= {ready, 28'b0, error, ists, busy};
          default:  rd_reg <= '0;
        endcase
      end
    end
  end

  assign cfg_rdata = rd_mb ? rsp_q : rd_reg;

  p_start_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    rsp_start |=> !rsp_start);
  p_start_busy_r7: assert property (@(posedge clk) disable iff (rst)
    rsp_start |-> busy);
  p_busy_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && !rsp_done && !rsp_discard && !abort_w) |=> busy);
  p_go_ignored_r7: assert property (@(posedge clk) disable iff (rst)
    (go_w && busy) |=> !rsp_start);
  p_ready_busy_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(ready && busy));
  p_last_pop_r10: assert property (@(posedge clk) disable iff (rst)
    last_pop |=> (!ready && rsp_len == '0));
  p_abort_clears_r11: assert property (@(posedge clk) disable iff (rst)
    abort_w |=> (!busy && !ready && !error));
  p_irq_gate_r12: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(intr_en));
  p_irq_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);
endmodule

// File: tb/doe_mailbox_bench.sv
`timescale 1ns/1ps
module doe_mailbox_bench;
  localparam int DEPTH = 16;
  localparam int AW = 4;
  localparam int PW = 2;
  localparam logic [4:0] A_CAP = 5'h04, A_CTRL = 5'h08, A_STAT = 5'h0C,
                         A_WMB = 5'h10, A_RMB = 5'h14;

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_wr = 0, cfg_rd = 0;
  logic [4:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata, req_rdata, rsp_wdata = '0;
  logic rsp_start, irq, rsp_wr = 0, rsp_done = 0, rsp_discard = 0;
  logic [PW-1:0] rsp_proto;
  logic [AW-1:0] req_raddr = '0;

  int n_chk = 0, n_fail = 0;
  logic [31:0] exp_req [DEPTH];

  always #2.5 clk = ~clk;

  doe_mailbox u_doe_mailbox (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .rsp_start(rsp_start),
    .rsp_proto(rsp_proto), .req_raddr(req_raddr), .req_rdata(req_rdata),
    .rsp_wr(rsp_wr), .rsp_wdata(rsp_wdata), .rsp_done(rsp_done),
    .rsp_discard(rsp_discard), .irq(irq));

  function automatic logic [31:0] proto_word(int i);
    case (i)
      0: return 32'h0000_0001;
      1: return 32'h0001_0001;
      2: return 32'h0042_1AB3;
      default: return 32'h0003_0001;   // not in the table
    endcase
  endfunction

  function automatic int proto_index(logic [31:0] w);
    for (int i = 0; i < 3; i++) if (proto_word(i) == w) return i;
    return -1;
  endfunction

  function automatic logic [31:0] rsp_word(int i, int tag);
    return 32'hC0DE_0000 + 32'(i) * 32'h0001_0003 + 32'(tag);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic cfg_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_rd = 1; cfg_addr = a;
    @(negedge clk);
    cfg_rd = 0;
    d = cfg_rdata;
  endtask

  // mode 0: done then pop all; 1: responder discards; 2: done then ABORT
  task automatic txn(input logic [31:0] p0, input int nw, input int lenf,
                     input int rn, input bit ien, input int mode);
    logic [31:0] d;
    int pi = proto_index(p0);
    bit ok = (pi >= 0) && (nw >= 2) && (nw <= DEPTH) && (lenf == nw);
    int tag = int'($urandom % 256);
    cfg_write(A_CTRL, {30'b0, ien, 1'b0});
    for (int i = 0; i < nw; i++) begin
      if (i == 0) d = p0;
      else if (i == 1) d = {$urandom} << 18 | 32'(lenf);
      else d = $urandom;
      if (i < DEPTH) exp_req[i] = d;
      cfg_write(A_WMB, d);
    end
    cfg_write(A_CTRL, {1'b1, 29'b0, ien, 1'b0});
    chk(ok ? "R5 start on valid GO" : "R6 no start on bad GO", {31'b0, rsp_start}, {31'b0, ok});
    if (!ok) begin
      cfg_read(A_STAT, d);
      chk("R6 status after discard", d, 32'h0);
      return;
    end
    chk("R5 protocol index", {30'b0, rsp_proto}, 32'(pi));
    cfg_read(A_STAT, d);
    chk("R7 busy after GO", d, 32'h1);
    cfg_write(A_CTRL, {1'b1, 29'b0, ien, 1'b0});
    chk("R7 GO while busy ignored", {31'b0, rsp_start}, 32'h0);
    for (int k = 0; k < 2; k++) begin
      int ix = (k == 0) ? 1 : nw - 1;
      @(negedge clk); req_raddr = AW'(ix);
      @(negedge clk);
      chk("R5 request buffer readback", req_rdata, exp_req[ix]);
    end
    if (mode == 1) begin
      @(negedge clk); rsp_discard = 1;
      @(negedge clk); rsp_discard = 0;
      chk("R12 irq on error", {31'b0, irq}, {31'b0, ien});
      cfg_read(A_STAT, d);
      chk("R8 error after discard", d, 32'h4 | {30'b0, ien, 1'b0});
      cfg_write(A_STAT, 32'h2);
      cfg_write(A_CTRL, {30'b0, ien, 1'b1});
      cfg_read(A_STAT, d);
      chk("R11 abort clears error", d, 32'h0);
      return;
    end
    for (int i = 0; i < rn; i++) begin
      @(negedge clk); rsp_wr = 1; rsp_wdata = rsp_word(i, tag);
    end
    @(negedge clk); rsp_wr = 0; rsp_done = 1;
    @(negedge clk); rsp_done = 0;
    chk("R12 irq on ready", {31'b0, irq}, {31'b0, ien});
    @(negedge clk);
    chk("R12 irq single pulse", {31'b0, irq}, 32'h0);
    cfg_read(A_STAT, d);
    chk("R8 ready after done", d, 32'h8000_0000 | {30'b0, ien, 1'b0});
    cfg_write(A_STAT, 32'h2);
    if (mode == 2) begin
      cfg_write(A_CTRL, {30'b0, ien, 1'b1});
      cfg_read(A_STAT, d);
      chk("R11 abort clears ready", d, 32'h0);
      cfg_read(A_RMB, d);
      chk("R11 mailbox empty after abort", d, 32'h0);
      return;
    end
    for (int i = 0; i < rn; i++) begin
      cfg_read(A_RMB, d);
      chk("R9 response dword", d, rsp_word(i, tag));
      if (i == rn - 1) begin
        cfg_read(A_STAT, d);
        chk("R10 ready before last pop", d, 32'h8000_0000);
      end
      cfg_write(A_RMB, $urandom);
    end
    cfg_read(A_STAT, d);
    chk("R10 ready cleared after last pop", d, 32'h0);
    cfg_read(A_RMB, d);
    chk("R9 read returns 0 when not ready", d, 32'h0);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 irq low after reset", {31'b0, irq}, 32'h0);
    chk("R1 start low after reset", {31'b0, rsp_start}, 32'h0);
    cfg_read(A_CAP, d);   chk("R1 R2 capability", d, 32'h0000_000B);
    cfg_read(A_CTRL, d);  chk("R1 control reset", d, 32'h0);
    cfg_read(A_STAT, d);  chk("R1 status reset", d, 32'h0);
    cfg_read(5'h06, d);   chk("R2 unaligned reads 0", d, 32'h0);
    cfg_read(5'h00, d);   chk("R2 header offset reads 0", d, 32'h0);
    cfg_read(A_RMB, d);   chk("R13 read latency, R9 idle mailbox", d, 32'h0);
    cfg_write(A_CTRL, 32'h8000_0002);
    cfg_read(A_CTRL, d);  chk("R3 control readback masks GO", d, 32'h2);
    cfg_write(A_CTRL, 32'h0);
    cfg_read(A_CTRL, d);  chk("R3 enable cleared", d, 32'h0);

    txn(proto_word(0), 2, 2, 1, 1, 0);               // shortest object
    txn(proto_word(2), DEPTH, DEPTH, DEPTH, 1, 0);   // full buffer, full response
    txn(proto_word(1), DEPTH + 1, DEPTH + 1, 1, 1, 0); // R4 overflow -> discard
    txn(proto_word(1), 5, 4, 1, 0, 0);               // R6 length mismatch
    txn(proto_word(3), 4, 4, 1, 1, 0);               // R6 unknown protocol
    txn(proto_word(1), 3, 3, 2, 0, 0);               // R6 next object from position 0
    txn(proto_word(0), 4, 4, 2, 1, 1);               // R8 responder discard
    txn(proto_word(1), 6, 6, 3, 1, 2);               // R11 abort while ready
    txn(proto_word(1), 1, 1, 1, 1, 0);               // R6 too short

    for (int t = 0; t < 40; t++) begin
      int nw  = 2 + int'($urandom % (DEPTH));
      int lf  = ($urandom % 4 == 0) ? nw + 1 : nw;
      int pi  = int'($urandom % 4);
      int rn  = 1 + int'($urandom % DEPTH);
      int md  = ($urandom % 5 == 0) ? 1 : 0;
      txn(proto_word(pi), nw, lf, rn, 1'($urandom), md);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule